// File: doc/BRIEF.md
# Duplicate Tag Coherence Filter

This block holds a second copy of the data-cache tags, arranged so that a physical block address can be looked up. The data cache is virtually indexed. The upper bits of a line index are virtual alias bits, so one physical block can live at any of several candidate lines. Those candidates share the page-offset index bits and differ only in the alias bits.

On a fill request the filter reads all candidate lines in one cycle and compares them with the request. It then emits a list of actions, one per handshake:

- **Writebacks** of modified lines.
- **Invalidations** of synonyms.
- **Evictions** of lines that would break inclusion in the direct-mapped second-level cache.
- **A final verdict**: either a normal grant, or a non-allocating fetch when an instruction fill collides with data-cache contents in the second level.

Probes look up the same copy through a port of their own, so they never wait for the fill sequencer and never touch the core's load/store path. A separate update port records a line once the cache has written it.

Top module: `dtag_filter`

## Requirements
- R1: After reset the filter has no pending action (`act_valid` low), accepts a fill (`fill_ready` high), and every duplicate entry is invalid, so any probe misses.
- R2: An update writes the entry at line `{upd_valias, upd_pa[3:0]}` as valid, with tag `upd_pa[19:4]` and modified flag `upd_mod`. If an update and a clear target the same line in the same cycle, the update wins.
- R3: A probe presented in any cycle, including while a fill is in progress, answers in the next cycle with `prb_rsp_valid` high. It compares the candidate lines `{a, prb_pa[3:0]}`. On a hit it returns `prb_hit` = 1, the matching line (lowest alias when several match) and its modified flag. On a miss it returns `prb_hit` = 0 and `prb_mod` = 0.
- R4: On a data fill (`fill_is_inst` = 0), a valid line at another alias of the same index holding the same tag gets an invalidate action (code 1) at that line.
- R5: On a data fill, a synonym line as in R4 that is modified gets a writeback action (code 0) before its invalidation.
- R6: On a data fill, every candidate line (requested alias included) holding a conflicting address gets an evict action (code 2), preceded by a writeback if it is modified. Two addresses conflict when tag bits [5:0] are equal and the full tags differ.
- R7: On an instruction fill, a candidate line holding the same tag in the modified state gets a writeback action. The line stays valid and is not invalidated.
- R8: On an instruction fill where any candidate line holds a conflicting address, the final action is a non-allocating fetch (code 4) instead of a grant (code 3). Conflicting lines get no action.
- R9: Actions come in this order: all writebacks, then invalidations, then evictions, each class in ascending alias order. Exactly one final action (grant or fetch, code 3 or 4) follows, at line `{fill_valias, fill_pa[3:0]}`.
- R10: An offered action keeps its code and line until `act_ready` is high. `fill_ready` is low from the cycle after a fill is accepted until the final action is taken.
- R11: A taken writeback clears the line's modified flag. A taken invalidate or evict clears the line's valid flag. These changes are visible to later probes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_valid | input | 1 | Fill request present |
| fill_ready | output | 1 | Filter idle, request taken when valid |
| fill_pa | input | 20 | Physical block address of the fill |
| fill_valias | input | 2 | Alias bits of the virtual line index |
| fill_is_inst | input | 1 | 1 = instruction fill, 0 = data fill |
| act_valid | output | 1 | Action offered |
| act_ready | input | 1 | Action taken when high with act_valid |
| act_code | output | 3 | 0 writeback, 1 invalidate, 2 evict, 3 grant, 4 non-allocating fetch |
| act_idx | output | 6 | Data-cache line the action applies to |
| upd_valid | input | 1 | Record a completed fill |
| upd_pa | input | 20 | Physical block address written |
| upd_valias | input | 2 | Alias bits of the written line |
| upd_mod | input | 1 | Modified flag to record |
| prb_valid | input | 1 | Probe lookup request |
| prb_pa | input | 20 | Probe physical block address |
| prb_rsp_valid | output | 1 | Probe answer present |
| prb_hit | output | 1 | Probe address found |
| prb_idx | output | 6 | Line holding the probed address |
| prb_mod | output | 1 | Modified flag of that line |

## Verification
The hardest situation to reach from the ports is one where the candidate lines of a single index mix several kinds of entry at once: a modified synonym, a clean synonym and conflicting addresses. Only such a mix shows the full writeback, invalidate and evict ordering in one stream. Random addresses would almost never land there. The stimulus therefore draws every address from a tiny pool: two index values, two conflict-index values and three upper tag values. Updates at random aliases then pile entries onto the same four candidate lines. Directed cases build the modified-synonym and instruction-fetch-conflict cases on purpose, and hold `act_ready` low while probing mid-sequence.

// File: rtl/cf_pkg.sv
package cf_pkg;

  typedef enum logic [2:0] {
    ACT_WB       = 3'd0,
    ACT_INV      = 3'd1,
    ACT_EVICT    = 3'd2,
    ACT_GRANT    = 3'd3,
    ACT_FETCH_NC = 3'd4
  } act_e;

endpackage

// File: rtl/cf_tag_store.sv
module cf_tag_store #(
  parameter int ALIAS_W = 2,
  parameter int LOW_W   = 4,
  parameter int TAG_W   = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ALIAS_W+LOW_W-1:0]         wr_idx,
  input  logic [TAG_W-1:0]                 wr_tag,
  input  logic                             wr_mod,
  input  logic                             clr_en,
  input  logic                             clr_inv,
  input  logic [ALIAS_W+LOW_W-1:0]         clr_idx,
  input  logic [LOW_W-1:0]                 fa_low,
  output logic [(1<<ALIAS_W)-1:0]          fa_vld,
  output logic [(1<<ALIAS_W)-1:0]          fa_mod,
  output logic [(1<<ALIAS_W)-1:0][TAG_W-1:0] fa_tag,
  input  logic [LOW_W-1:0]                 pa_low,
  output logic [(1<<ALIAS_W)-1:0]          pa_vld,
  output logic [(1<<ALIAS_W)-1:0]          pa_mod,
  output logic [(1<<ALIAS_W)-1:0][TAG_W-1:0] pa_tag
);
  localparam int IDX_W   = ALIAS_W + LOW_W;
  localparam int N_LINES = 1 << IDX_W;
  localparam int N_ALIAS = 1 << ALIAS_W;

  logic [N_LINES-1:0] vld_q, vld_d;
  logic [N_LINES-1:0] mod_q, mod_d;
  logic [TAG_W-1:0]   tag_q [N_LINES];

  always_comb begin
    vld_d = vld_q;
    mod_d = mod_q;
    if (clr_en) begin
      if (clr_inv) vld_d[clr_idx] = 1'b0;
      mod_d[clr_idx] = 1'b0;
    end
    if (wr_en) begin
      vld_d[wr_idx] = 1'b1;
      mod_d[wr_idx] = wr_mod;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      mod_q <= '0;
    end else begin
      vld_q <= vld_d;
      mod_q <= mod_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  for (genvar a = 0; a < N_ALIAS; a++) begin : g_rd
    localparam logic [ALIAS_W-1:0] AL = ALIAS_W'(a);
    assign fa_vld[a] = vld_q[{AL, fa_low}];
    assign fa_mod[a] = mod_q[{AL, fa_low}];
    assign fa_tag[a] = tag_q[{AL, fa_low}];
    assign pa_vld[a] = vld_q[{AL, pa_low}];
    assign pa_mod[a] = mod_q[{AL, pa_low}];
    assign pa_tag[a] = tag_q[{AL, pa_low}];
  end

  // R2: a written line reads back valid
  a_r2_write_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_idx)]);
  // R11: an invalidating clear without a colliding write drops the line
  a_r11_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && clr_inv && !(wr_en && wr_idx == clr_idx)) |=> !vld_q[$past(clr_idx)]);

endmodule

// File: rtl/cf_alias_cmp.sv
module cf_alias_cmp #(
  parameter int ALIAS_W = 2,
  parameter int TAG_W   = 16,
  parameter int CONF_W  = 6
) (
  input  logic [(1<<ALIAS_W)-1:0]            vld,
  input  logic [(1<<ALIAS_W)-1:0][TAG_W-1:0] tag,
  input  logic [TAG_W-1:0]                   req_tag,
  output logic [(1<<ALIAS_W)-1:0]            same_m,
  output logic [(1<<ALIAS_W)-1:0]            conf_m
);
  localparam int N_ALIAS = 1 << ALIAS_W;

  for (genvar a = 0; a < N_ALIAS; a++) begin : g_cmp
    logic tag_eq, l2_eq;
    assign tag_eq    = (tag[a] == req_tag);
    assign l2_eq     = (tag[a][CONF_W-1:0] == req_tag[CONF_W-1:0]);
    assign same_m[a] = vld[a] && tag_eq;
    assign conf_m[a] = vld[a] && l2_eq && !tag_eq;
  end

endmodule

// File: rtl/cf_fill_seq.sv
module cf_fill_seq
  import cf_pkg::*;
#(
  parameter int ALIAS_W = 2,
  parameter int LOW_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fill_valid,
  output logic                       fill_ready,
  input  logic [ALIAS_W-1:0]         fill_valias,
  input  logic [LOW_W-1:0]           fill_low,
  input  logic                       fill_is_inst,
  input  logic [(1<<ALIAS_W)-1:0]    same_m,
  input  logic [(1<<ALIAS_W)-1:0]    conf_m,
  input  logic [(1<<ALIAS_W)-1:0]    mod_m,
  output logic                       act_valid,
  input  logic                       act_ready,
  output logic [2:0]                 act_code,
  output logic [ALIAS_W+LOW_W-1:0]   act_idx,
  output logic                       clr_en,
  output logic                       clr_inv,
  output logic [ALIAS_W+LOW_W-1:0]   clr_idx
);
  localparam int N_ALIAS = 1 << ALIAS_W;

  logic               busy_q, busy_d;
  logic               inst_q, inst_d;
  logic               nc_q, nc_d;
  logic [ALIAS_W-1:0] va_q, va_d;
  logic [LOW_W-1:0]   low_q, low_d;
  logic [N_ALIAS-1:0] wb_q, wb_d, inv_q, inv_d, ev_q, ev_d;

  logic [N_ALIAS-1:0] self_m, wb_new, inv_new, ev_new;
  logic               nc_new;
  logic               accept, fire, final_act;
  logic [N_ALIAS-1:0] cur_m;
  logic [ALIAS_W-1:0] sel;
  act_e               code;

  assign accept     = fill_valid && !busy_q;
  assign fill_ready = !busy_q;
  assign self_m     = N_ALIAS'(1) << fill_valias;

  always_comb begin
    if (fill_is_inst) begin
      wb_new  = same_m & mod_m;
      inv_new = '0;
      ev_new  = '0;
      nc_new  = |conf_m;
    end else begin
      wb_new  = (same_m & ~self_m & mod_m) | (conf_m & mod_m);
      inv_new = same_m & ~self_m;
      ev_new  = conf_m;
      nc_new  = 1'b0;
    end
  end

  always_comb begin
    final_act = 1'b0;
    cur_m     = '0;
    if (|wb_q) begin
      code  = ACT_WB;
      cur_m = wb_q;
    end else if (|inv_q) begin
      code  = ACT_INV;
      cur_m = inv_q;
    end else if (|ev_q) begin
      code  = ACT_EVICT;
      cur_m = ev_q;
    end else begin
      code      = nc_q ? ACT_FETCH_NC : ACT_GRANT;
      final_act = 1'b1;
    end
    sel = '0;
    for (int a = N_ALIAS - 1; a >= 0; a--) begin
      if (cur_m[a]) sel = ALIAS_W'(a);
    end
  end

  assign act_valid = busy_q;
  assign act_code  = code;
  assign act_idx   = final_act ? {va_q, low_q} : {sel, low_q};
  assign fire      = busy_q && act_ready;
  assign clr_en    = fire && !final_act;
  assign clr_inv   = (code != ACT_WB);
  assign clr_idx   = {sel, low_q};

  always_comb begin
    busy_d = busy_q;
    inst_d = inst_q;
    nc_d   = nc_q;
    va_d   = va_q;
    low_d  = low_q;
    wb_d   = wb_q;
    inv_d  = inv_q;
    ev_d   = ev_q;
    if (accept) begin
      busy_d = 1'b1;
      inst_d = fill_is_inst;
      nc_d   = nc_new;
      va_d   = fill_valias;
      low_d  = fill_low;
      wb_d   = wb_new;
      inv_d  = inv_new;
      ev_d   = ev_new;
    end else if (fire) begin
      case (code)
        ACT_WB:    wb_d[sel]  = 1'b0;
        ACT_INV:   inv_d[sel] = 1'b0;
        ACT_EVICT: ev_d[sel]  = 1'b0;
        default:   busy_d     = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      inst_q <= 1'b0;
      nc_q   <= 1'b0;
      va_q   <= '0;
      low_q  <= '0;
      wb_q   <= '0;
      inv_q  <= '0;
      ev_q   <= '0;
    end else begin
      busy_q <= busy_d;
      inst_q <= inst_d;
      nc_q   <= nc_d;
      va_q   <= va_d;
      low_q  <= low_d;
      wb_q   <= wb_d;
      inv_q  <= inv_d;
      ev_q   <= ev_d;
    end
  end

  a_r10_hold_action: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && !act_ready) |=> (act_valid && $stable(act_code) && $stable(act_idx)));
  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready) |=> (act_valid && !fill_ready));
  a_r9_no_wb_after_other: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && act_ready && act_code != 3'd0) |=> !(act_valid && act_code == 3'd0));
  a_r9_single_final: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && act_ready && (act_code == 3'd3 || act_code == 3'd4)) |=> !act_valid);
  a_r8_fetch_only_inst: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && act_code == 3'd4) |-> inst_q);

endmodule

// File: rtl/dtag_filter.sv
module dtag_filter #(
  parameter int PA_W     = 20,
  parameter int DC_IDX_W = 6,
  parameter int ALIAS_W  = 2,
  parameter int L2_IDX_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fill_valid,
  output logic                fill_ready,
  input  logic [PA_W-1:0]     fill_pa,
  input  logic [ALIAS_W-1:0]  fill_valias,
  input  logic                fill_is_inst,
  output logic                act_valid,
  input  logic                act_ready,
  output logic [2:0]          act_code,
  output logic [DC_IDX_W-1:0] act_idx,
  input  logic                upd_valid,
  input  logic [PA_W-1:0]     upd_pa,
  input  logic [ALIAS_W-1:0]  upd_valias,
  input  logic                upd_mod,
  input  logic                prb_valid,
  input  logic [PA_W-1:0]     prb_pa,
  output logic                prb_rsp_valid,
  output logic                prb_hit,
  output logic [DC_IDX_W-1:0] prb_idx,
  output logic                prb_mod
);
  localparam int LOW_W   = DC_IDX_W - ALIAS_W;
  localparam int TAG_W   = PA_W - LOW_W;
  localparam int CONF_W  = L2_IDX_W - LOW_W;
  localparam int N_ALIAS = 1 << ALIAS_W;

  logic [N_ALIAS-1:0]            fa_vld, fa_mod, pa_vld, pa_mod;
  logic [N_ALIAS-1:0][TAG_W-1:0] fa_tag, pa_tag;
  logic [N_ALIAS-1:0]            f_same, f_conf, p_same, p_conf_unused;
  logic                          clr_en, clr_inv;
  logic [DC_IDX_W-1:0]           clr_idx;

  cf_tag_store #(.ALIAS_W(ALIAS_W), .LOW_W(LOW_W), .TAG_W(TAG_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (upd_valid),
    .wr_idx  ({upd_valias, upd_pa[LOW_W-1:0]}),
    .wr_tag  (upd_pa[PA_W-1:LOW_W]),
    .wr_mod  (upd_mod),
    .clr_en  (clr_en),
    .clr_inv (clr_inv),
    .clr_idx (clr_idx),
    .fa_low  (fill_pa[LOW_W-1:0]),
    .fa_vld  (fa_vld),
    .fa_mod  (fa_mod),
    .fa_tag  (fa_tag),
    .pa_low  (prb_pa[LOW_W-1:0]),
    .pa_vld  (pa_vld),
    .pa_mod  (pa_mod),
    .pa_tag  (pa_tag)
  );

  cf_alias_cmp #(.ALIAS_W(ALIAS_W), .TAG_W(TAG_W), .CONF_W(CONF_W)) u_fill_cmp (
    .vld     (fa_vld),
    .tag     (fa_tag),
    .req_tag (fill_pa[PA_W-1:LOW_W]),
    .same_m  (f_same),
    .conf_m  (f_conf)
  );

  cf_alias_cmp #(.ALIAS_W(ALIAS_W), .TAG_W(TAG_W), .CONF_W(CONF_W)) u_prb_cmp (
    .vld     (pa_vld),
    .tag     (pa_tag),
    .req_tag (prb_pa[PA_W-1:LOW_W]),
    .same_m  (p_same),
    .conf_m  (p_conf_unused)
  );

  cf_fill_seq #(.ALIAS_W(ALIAS_W), .LOW_W(LOW_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .fill_valid   (fill_valid),
    .fill_ready   (fill_ready),
    .fill_valias  (fill_valias),
    .fill_low     (fill_pa[LOW_W-1:0]),
    .fill_is_inst (fill_is_inst),
    .same_m       (f_same),
    .conf_m       (f_conf),
    .mod_m        (fa_mod),
    .act_valid    (act_valid),
    .act_ready    (act_ready),
    .act_code     (act_code),
    .act_idx      (act_idx),
    .clr_en       (clr_en),
    .clr_inv      (clr_inv),
    .clr_idx      (clr_idx)
  );

  // probe answer: lowest matching alias, registered one cycle
  logic                hit_d, mod_d;
  logic [ALIAS_W-1:0]  hsel;
  logic                rsp_q, hit_q, pmod_q;
  logic [DC_IDX_W-1:0] pidx_q;

  always_comb begin
    hsel = '0;
    for (int a = N_ALIAS - 1; a >= 0; a--) begin
      if (p_same[a]) hsel = ALIAS_W'(a);
    end
    hit_d = |p_same;
    mod_d = hit_d && pa_mod[hsel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q  <= 1'b0;
      hit_q  <= 1'b0;
      pmod_q <= 1'b0;
      pidx_q <= '0;
    end else begin
      rsp_q <= prb_valid;
      if (prb_valid) begin
        hit_q  <= hit_d;
        pmod_q <= mod_d;
        pidx_q <= {hsel, prb_pa[LOW_W-1:0]};
      end
    end
  end

  assign prb_rsp_valid = rsp_q;
  assign prb_hit       = hit_q;
  assign prb_mod       = pmod_q;
  assign prb_idx       = pidx_q;

  a_r3_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
    prb_valid |=> prb_rsp_valid);
  a_r3_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (prb_rsp_valid && !prb_hit) |-> !prb_mod);
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !prb_valid |=> !prb_rsp_valid);

endmodule

// File: tb/tb_dtag_filter.sv
module tb_dtag_filter;
  localparam int PA_W = 20, IDX_W = 6, AW = 2, LOW_W = 4, TAG_W = 16, CONF_W = 6;
  localparam int NL = 64;

  logic clk = 1'b0;
  logic rst_n;
  logic fill_valid, fill_ready, fill_is_inst;
  logic [PA_W-1:0] fill_pa, upd_pa, prb_pa;
  logic [AW-1:0] fill_valias, upd_valias;
  logic act_valid, act_ready;
  logic [2:0] act_code;
  logic [IDX_W-1:0] act_idx, prb_idx;
  logic upd_valid, upd_mod, prb_valid, prb_rsp_valid, prb_hit, prb_mod;

  always #5 clk = ~clk;

  dtag_filter dut (.*);

  int total = 0, failed = 0, cyc = 0;
  logic m_v [NL];
  logic m_m [NL];
  logic [TAG_W-1:0] m_t [NL];
  logic [2:0] e_code [16];
  logic [IDX_W-1:0] e_idx [16];
  int e_n;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; failed++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  function automatic logic [PA_W-1:0] pick_pa();
    logic [9:0] up = 10'($urandom % 3);
    logic [5:0] ex = 6'($urandom % 2);
    logic [3:0] lo = 4'($urandom % 2);
    return {up, ex, lo};
  endfunction

  task automatic push(input logic [2:0] c, input logic [IDX_W-1:0] i);
    e_code[e_n] = c; e_idx[e_n] = i; e_n++;
  endtask

  // expected action list from the requirements
  task automatic expect_fill(input logic [PA_W-1:0] pa, input logic [AW-1:0] va, input logic inst);
    logic [TAG_W-1:0] rt = pa[PA_W-1:LOW_W];
    logic [3:0] same, conf, md;
    e_n = 0;
    for (int a = 0; a < 4; a++) begin
      int i = a * 16 + int'(pa[3:0]);
      same[a] = m_v[i] && m_t[i] == rt;
      conf[a] = m_v[i] && m_t[i][CONF_W-1:0] == rt[CONF_W-1:0] && m_t[i] != rt;
      md[a]   = m_m[i];
    end
    for (int a = 0; a < 4; a++)
      if (inst ? (same[a] && md[a]) : (((same[a] && a != int'(va)) || conf[a]) && md[a]))
        push(3'd0, {2'(a), pa[3:0]});
    if (!inst) begin
      for (int a = 0; a < 4; a++) if (same[a] && a != int'(va)) push(3'd1, {2'(a), pa[3:0]});
      for (int a = 0; a < 4; a++) if (conf[a]) push(3'd2, {2'(a), pa[3:0]});
    end
    push((inst && |conf) ? 3'd4 : 3'd3, {va, pa[3:0]});
  endtask

  task automatic do_upd(input logic [PA_W-1:0] pa, input logic [AW-1:0] va, input logic md);
    int i = {va, pa[3:0]};
    @(negedge clk);
    upd_valid = 1'b1; upd_pa = pa; upd_valias = va; upd_mod = md;
    @(negedge clk);
    upd_valid = 1'b0;
    m_v[i] = 1'b1; m_m[i] = md; m_t[i] = pa[PA_W-1:LOW_W];
  endtask

  task automatic model_probe(input logic [PA_W-1:0] pa, output logic h, output logic [IDX_W-1:0] ix, output logic md);
    h = 1'b0; ix = {2'b00, pa[3:0]}; md = 1'b0;
    for (int a = 3; a >= 0; a--) begin
      int i = a * 16 + int'(pa[3:0]);
      if (m_v[i] && m_t[i] == pa[PA_W-1:LOW_W]) begin
        h = 1'b1; ix = 6'(i); md = m_m[i];
      end
    end
  endtask

  task automatic check_probe_rsp(input logic [PA_W-1:0] pa, input string rq);
    logic h, md;
    logic [IDX_W-1:0] ix;
    model_probe(pa, h, ix, md);
    chk(rq, prb_rsp_valid, 1);
    chk(rq, prb_hit, h);
    if (h) chk(rq, prb_idx, ix);
    chk(rq, prb_mod, md);
  endtask

  task automatic do_probe(input logic [PA_W-1:0] pa, input string rq);
    @(negedge clk);
    prb_valid = 1'b1; prb_pa = pa;
    @(negedge clk);
    prb_valid = 1'b0;
    check_probe_rsp(pa, rq);
  endtask

  task automatic do_fill(input logic [PA_W-1:0] pa, input logic [AW-1:0] va, input logic inst, input logic probe_mid);
    int k = 0;
    int guard = 0;
    logic stalled = 1'b0;
    expect_fill(pa, va, inst);
    @(negedge clk);
    chk("R10", fill_ready, 1);
    fill_valid = 1'b1; fill_pa = pa; fill_valias = va; fill_is_inst = inst;
    @(negedge clk);
    fill_valid = 1'b0;
    chk("R10", fill_ready, 0);
    if (probe_mid) begin
      act_ready = 1'b0;
      prb_valid = 1'b1; prb_pa = pa;
      @(negedge clk);
      prb_valid = 1'b0;
      check_probe_rsp(pa, "R3");
      chk("R10", act_valid, 1);
    end
    while (k < e_n && guard < 200) begin
      string rq;
      logic r;
      guard++;
      if (!act_valid) begin
        chk("R9", act_valid, 1);
        break;
      end
      if (stalled) rq = "R10";
      else if (e_code[k] == 3'd0) rq = inst ? "R7" : "R5";
      else if (e_code[k] == 3'd1) rq = "R4";
      else if (e_code[k] == 3'd2) rq = "R6";
      else if (e_code[k] == 3'd4) rq = "R8";
      else rq = "R9";
      chk(rq, act_code, e_code[k]);
      chk("R9", act_idx, e_idx[k]);
      r = ($urandom % 3) != 0;
      act_ready = r;
      @(negedge clk);
      stalled = !r;
      if (r) begin
        int i = e_idx[k];
        if (e_code[k] == 3'd0) m_m[i] = 1'b0;
        if (e_code[k] == 3'd1 || e_code[k] == 3'd2) begin m_v[i] = 1'b0; m_m[i] = 1'b0; end
        k++;
      end
    end
    act_ready = 1'b0;
    chk("R9", act_valid, 0);
    chk("R10", fill_ready, 1);
  endtask

  initial begin
    rst_n = 1'b0;
    fill_valid = 0; fill_pa = 0; fill_valias = 0; fill_is_inst = 0;
    act_ready = 0; upd_valid = 0; upd_pa = 0; upd_valias = 0; upd_mod = 0;
    prb_valid = 0; prb_pa = 0;
    for (int i = 0; i < NL; i++) begin m_v[i] = 0; m_m[i] = 0; m_t[i] = 0; end
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", act_valid, 0);
    chk("R1", fill_ready, 1);
    chk("R1", prb_rsp_valid, 0);
    do_probe(20'h00000, "R1");
    chk("R1", prb_hit, 0);

    // directed: modified synonym then data fill at another alias
    do_upd(20'h00403, 2'd1, 1'b1);
    do_probe(20'h00403, "R2");
    chk("R2", prb_idx, 6'h13);
    do_fill(20'h00403, 2'd2, 1'b0, 1'b1);
    do_probe(20'h00403, "R11");
    // directed: conflict at requested alias and another, one modified
    do_upd(20'h00805, 2'd0, 1'b1);
    do_upd(20'h00C05, 2'd3, 1'b0);
    do_fill(20'h00405, 2'd0, 1'b0, 1'b0);
    do_probe(20'h00805, "R11");
    chk("R6", prb_hit, 0);
    // directed: instruction fill, modified same line plus a conflict
    do_upd(20'h00407, 2'd1, 1'b1);
    do_upd(20'h00807, 2'd2, 1'b0);
    do_fill(20'h00407, 2'd0, 1'b1, 1'b0);
    do_probe(20'h00407, "R7");
    chk("R7", prb_hit, 1);
    do_probe(20'h00807, "R8");
    chk("R8", prb_hit, 1);
    // directed: update wins over a same-cycle clear is not reachable here; random mix
    for (int n = 0; n < 600; n++) begin
      int op = $urandom % 10;
      logic [PA_W-1:0] pa = pick_pa();
      logic [AW-1:0] va = 2'($urandom % 4);
      if (op < 4) do_upd(pa, va, 1'($urandom % 2));
      else if (op < 8) begin
        logic inst = 1'($urandom % 2);
        do_fill(pa, va, inst, ($urandom % 5) == 0);
        if (!inst && ($urandom % 2) == 1) do_upd(pa, va, 1'($urandom % 2));
      end else do_probe(pa, "R3");
    end
    finish_run();
  end
endmodule